// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 32-bit physical address by walking a two-level page table that lives in memory. A requester presents a virtual address together with the access kind (read or write) and the privilege level (user or supervisor), plus the physical base of the top-level table. The walker fetches the top-level entry, then the second-level entry. At each step it checks presence, and it checks the combined write and user permissions once both entries are known. It then returns a physical address or a fault cause.

When a walk succeeds, the walker records the use in the entries themselves. It sets the accessed flag in both entries, and on a write it also sets the dirty flag in the leaf entry. An entry is written back only when one of its bits actually changes, so a walk costs two reads and zero to two writes. Memory is reached through a single request/acknowledge port that carries one 32-bit word per transfer. One walk runs at a time. The block shows a busy flag and a one-cycle completion strobe.

Top module: `page_walker`

## Requirements
- R1: On success the physical address is the leaf entry's bits 31..12 followed by the virtual address bits 11..0 unchanged.
- R2: The first read goes to {base[31:12], va[31:22], 2'b00}. The second read goes to {top entry[31:12], va[21:12], 2'b00}. The top-level read always comes first.
- R3: If the top-level entry has bit 0 (present) clear, the walk ends with cause 1 (absent). No second read and no write take place.
- R4: If the leaf entry has bit 0 clear, the walk ends with cause 1 and no write.
- R5: If the top-level entry has bit 7 (large page) set while present, the walk ends with cause 3 (unsupported). No second read takes place.
- R6: A write request faults with cause 2 (protection) unless bit 1 (writable) is set in both entries. Nothing is written back.
- R7: A user request faults with cause 2 unless bit 2 (user) is set in both entries. Supervisor requests ignore bit 2.
- R8: A successful walk sets bit 5 (accessed) in both entries. Each entry is written back only if its value changes, the top-level entry first.
- R9: A successful write also sets bit 6 (dirty) of the leaf entry only. The top-level entry's bit 6 is left as it was.
- R10: A request is accepted only while busy is low, and busy is high from the next cycle until completion. Requests presented while busy are ignored.
- R11: done is a one-cycle pulse. With it come the physical address (zero on a fault), done_fault, and the cause (0 on success). After reset, busy, done and mem_req are low.
- R12: A memory request holds its address, direction and data stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken when not busy) |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| dir_base | input | 32 | Physical base of the top-level table (bits 31..12 used) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | 0 none, 1 absent, 2 protection, 3 unsupported large page |
| done_paddr | output | 32 | Translated physical address |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Word address (byte address, word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer complete; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Random walks draw the flag bits of both entries independently, with presence mostly set and the large-page bit occasionally set. This mix covers absent top-level entries, absent leaves, unsupported large pages, protection faults from either level, and clean hits. Directed walks then separate the write-back cases: accessed and dirty already set (no write), accessed set but dirty clear on a write (leaf write only), and fresh entries (both writes). They also separate supervisor access to user-only pages from user access to supervisor pages. Memory acknowledge latency is randomised, and one walk is hit with a competing request while busy.

// File: rtl/pw_pkg.sv
package pw_pkg;
   localparam int BIT_P  = 0;
   localparam int BIT_RW = 1;
   localparam int BIT_US = 2;
   localparam int BIT_A  = 5;
   localparam int BIT_D  = 6;
   localparam int BIT_PS = 7;

   typedef enum logic [1:0] {
      CAUSE_NONE   = 2'd0,
      CAUSE_ABSENT = 2'd1,
      CAUSE_PROT   = 2'd2,
      CAUSE_LARGE  = 2'd3
   } cause_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DIR,
      ST_RD_TBL,
      ST_WB_DIR,
      ST_WB_TBL,
      ST_FIN
   } state_e;
endpackage

// File: rtl/pw_entry_decode.sv
module pw_entry_decode #(
   parameter int ENT_W = 32,
   parameter int OFS_W = 12
) (
   input  logic [ENT_W-1:0]       entry_i,
   output logic                   present_o,
   output logic                   wr_ok_o,
   output logic                   user_ok_o,
   output logic                   large_o,
   output logic [ENT_W-OFS_W-1:0] base_o
);
   import pw_pkg::*;

   assign present_o = entry_i[BIT_P];
   assign wr_ok_o   = entry_i[BIT_RW];
   assign user_ok_o = entry_i[BIT_US];
   assign large_o   = entry_i[BIT_PS];
   assign base_o    = entry_i[ENT_W-1:OFS_W];

   logic unused_bits;
   assign unused_bits = ^entry_i;
endmodule

// File: rtl/pw_flag_merge.sv
module pw_flag_merge #(
   parameter int ENT_W = 32
) (
   input  logic [ENT_W-1:0] pde_i,
   input  logic [ENT_W-1:0] pte_i,
   input  logic             is_write_i,
   output logic [ENT_W-1:0] pde_o,
   output logic [ENT_W-1:0] pte_o,
   output logic             pde_chg_o,
   output logic             pte_chg_o
);
   import pw_pkg::*;

   localparam logic [ENT_W-1:0] MASK_A = ENT_W'(1) << BIT_A;
   localparam logic [ENT_W-1:0] MASK_D = ENT_W'(1) << BIT_D;

   always_comb begin
      pde_o = pde_i | MASK_A;
      pte_o = pte_i | MASK_A | (is_write_i ? MASK_D : '0);
   end

   assign pde_chg_o = (pde_o != pde_i);
   assign pte_chg_o = (pte_o != pte_i);
endmodule

// File: rtl/page_walker.sv
module page_walker #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 10,
   parameter int OFS_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              req_write,
   input  logic              req_user,
   input  logic [ADDR_W-1:0] dir_base,
   output logic              busy,
   output logic              done,
   output logic              done_fault,
   output logic [1:0]        done_cause,
   output logic [ADDR_W-1:0] done_paddr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rdata
);
   import pw_pkg::*;

   localparam int PN_W   = ADDR_W - OFS_W;
   localparam int ENT_SH = OFS_W - IDX_W;
   localparam int LEVELS = 2;

   generate
      if (ADDR_W != 2 * IDX_W + OFS_W) begin : g_bad_split
         $error("page_walker: address split does not cover ADDR_W");
      end
      if (ENT_SH < 1 || (8 << ENT_SH) != ADDR_W) begin : g_bad_entry
         $error("page_walker: a table of 2**IDX_W entries must fill one page");
      end
   endgenerate

   state_e            state_q;
   cause_e            cause_q;
   logic [ADDR_W-1:0] va_q;
   logic              wr_q;
   logic              usr_q;
   logic [PN_W-1:0]   base_q;
   logic [ADDR_W-1:0] pde_q;
   logic [ADDR_W-1:0] new_pde_q;
   logic [ADDR_W-1:0] new_pte_q;
   logic              wb_dir_q;
   logic              wb_tbl_q;
   logic [ADDR_W-1:0] paddr_q;

   // per-level decode of the entry in flight
   logic [ADDR_W-1:0] lvl_ent [LEVELS];
   logic [LEVELS-1:0] lvl_p;
   logic [LEVELS-1:0] lvl_rw;
   logic [LEVELS-1:0] lvl_us;
   logic [LEVELS-1:0] lvl_large;
   logic [PN_W-1:0]   lvl_base [LEVELS];

   assign lvl_ent[0] = (state_q == ST_RD_DIR) ? mem_rdata : pde_q;
   assign lvl_ent[1] = mem_rdata;

   generate
      for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
         pw_entry_decode #(.ENT_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
            .entry_i   (lvl_ent[g]),
            .present_o (lvl_p[g]),
            .wr_ok_o   (lvl_rw[g]),
            .user_ok_o (lvl_us[g]),
            .large_o   (lvl_large[g]),
            .base_o    (lvl_base[g])
         );
      end
   endgenerate

   logic unused_large;
   assign unused_large = lvl_large[1];

   logic perm_bad;
   assign perm_bad = (wr_q & ~(&lvl_rw)) | (usr_q & ~(&lvl_us));

   logic [ADDR_W-1:0] mrg_pde, mrg_pte;
   logic              mrg_pde_chg, mrg_pte_chg;

   pw_flag_merge #(.ENT_W(ADDR_W)) u_merge (
      .pde_i      (pde_q),
      .pte_i      (mem_rdata),
      .is_write_i (wr_q),
      .pde_o      (mrg_pde),
      .pte_o      (mrg_pte),
      .pde_chg_o  (mrg_pde_chg),
      .pte_chg_o  (mrg_pte_chg)
   );

   logic [IDX_W-1:0]  idx_dir, idx_tbl;
   logic [ADDR_W-1:0] dir_addr, tbl_addr;

   assign idx_dir  = va_q[ADDR_W-1 -: IDX_W];
   assign idx_tbl  = va_q[OFS_W +: IDX_W];
   assign dir_addr = {base_q, idx_dir, {ENT_SH{1'b0}}};
   assign tbl_addr = {lvl_base[0], idx_tbl, {ENT_SH{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cause_q   <= CAUSE_NONE;
         va_q      <= '0;
         wr_q      <= 1'b0;
         usr_q     <= 1'b0;
         base_q    <= '0;
         pde_q     <= '0;
         new_pde_q <= '0;
         new_pte_q <= '0;
         wb_dir_q  <= 1'b0;
         wb_tbl_q  <= 1'b0;
         paddr_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q    <= req_vaddr;
                  wr_q    <= req_write;
                  usr_q   <= req_user;
                  base_q  <= dir_base[ADDR_W-1:OFS_W];
                  cause_q <= CAUSE_NONE;
                  paddr_q <= '0;
                  state_q <= ST_RD_DIR;
               end
            end
            ST_RD_DIR: begin
               if (mem_ack) begin
                  pde_q <= mem_rdata;
                  if (!lvl_p[0]) begin
                     cause_q <= CAUSE_ABSENT;
                     state_q <= ST_FIN;
                  end else if (lvl_large[0]) begin
                     cause_q <= CAUSE_LARGE;
                     state_q <= ST_FIN;
                  end else begin
                     state_q <= ST_RD_TBL;
                  end
               end
            end
            ST_RD_TBL: begin
               if (mem_ack) begin
                  if (!lvl_p[1]) begin
                     cause_q <= CAUSE_ABSENT;
                     state_q <= ST_FIN;
                  end else if (perm_bad) begin
                     cause_q <= CAUSE_PROT;
                     state_q <= ST_FIN;
                  end else begin
                     paddr_q   <= {lvl_base[1], va_q[OFS_W-1:0]};
                     new_pde_q <= mrg_pde;
                     new_pte_q <= mrg_pte;
                     wb_dir_q  <= mrg_pde_chg;
                     wb_tbl_q  <= mrg_pte_chg;
                     if (mrg_pde_chg)      state_q <= ST_WB_DIR;
                     else if (mrg_pte_chg) state_q <= ST_WB_TBL;
                     else                  state_q <= ST_FIN;
                  end
               end
            end
            ST_WB_DIR: begin
               if (mem_ack) state_q <= wb_tbl_q ? ST_WB_TBL : ST_FIN;
            end
            ST_WB_TBL: begin
               if (mem_ack) state_q <= ST_FIN;
            end
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = tbl_addr;
      mem_wdata = new_pte_q;
      unique case (state_q)
         ST_RD_DIR: begin mem_req = 1'b1; mem_addr = dir_addr; end
         ST_RD_TBL: begin mem_req = 1'b1; end
         ST_WB_DIR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dir_addr; mem_wdata = new_pde_q; end
         ST_WB_TBL: begin mem_req = 1'b1; mem_we = 1'b1; end
         default: ;
      endcase
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = (state_q == ST_FIN);
   assign done_fault = done && (cause_q != CAUSE_NONE);
   assign done_cause = done ? cause_q : CAUSE_NONE;
   assign done_paddr = done ? paddr_q : '0;
endmodule

// File: rtl/pw_chk.sv
module pw_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              done_fault,
   input logic [1:0]        done_cause,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata
);
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   // R12
   hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R12
   hold_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

   // R8
   wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[5]);

   // R3
   fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_fault == (done_cause != 2'd0)));
endmodule

bind page_walker pw_chk #(.ADDR_W(ADDR_W)) u_pw_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .busy       (busy),
   .done       (done),
   .done_fault (done_fault),
   .done_cause (done_cause),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_ack    (mem_ack),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata)
);

// File: tb/test_page_walker.sv
module test_page_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        req_user = 1'b0;
   logic [31:0] dir_base = '0;
   logic        busy, done, done_fault;
   logic [1:0]  done_cause;
   logic [31:0] done_paddr;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack;
   logic [31:0] mem_rdata;

   always #5 clk = ~clk;

   page_walker i_page_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
      .busy(busy), .done(done), .done_fault(done_fault), .done_cause(done_cause),
      .done_paddr(done_paddr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   logic [31:0] mem [logic [31:0]];
   logic [31:0] rd_log [int];
   int          rd_cnt = 0;
   int          wr_cnt = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   logic [31:0] base_g = 32'h0001_3000;

   function automatic logic [31:0] peek(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic mem_model();
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      forever begin
         @(posedge clk);
         if (mem_ack) mem_ack <= 1'b0;
         else if (rst_n && mem_req && ($urandom_range(0, 3) != 0)) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               mem[mem_addr] = mem_wdata;
               wr_cnt++;
            end else begin
               mem_rdata <= peek(mem_addr);
               rd_log[rd_cnt] = mem_addr;
               rd_cnt++;
            end
         end
      end
   endtask

   task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", r, act, exp);
      end
   endtask

   // independent model of the translation rules
   task automatic model(input logic [31:0] pde, pte, input logic wr, usr, input logic [31:0] va,
                        output logic [1:0] cause, output logic [31:0] pa, npde, npte,
                        output int nrd, nwr);
      cause = 2'd0; pa = 32'h0; npde = pde; npte = pte; nrd = 2; nwr = 0;
      if (!pde[0])      begin cause = 2'd1; nrd = 1; end  // R3
      else if (pde[7])  begin cause = 2'd3; nrd = 1; end  // R5
      else if (!pte[0]) cause = 2'd1;                     // R4
      else if ((wr && !(pde[1] && pte[1])) || (usr && !(pde[2] && pte[2]))) cause = 2'd2; // R6 R7
      else begin
         pa   = {pte[31:12], va[11:0]};                   // R1
         npde = pde | 32'h20;                             // R8
         npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);     // R9
         nwr  = (npde != pde) + (npte != pte);
      end
   endtask

   task automatic do_walk(input logic [31:0] va, input logic wr, usr,
                          input logic [31:0] pde_in, pte_in, input bit intr, input string tag);
      logic [31:0] dir_a, tbl_a, pa, npde, npte;
      logic [1:0]  cause;
      int          nrd, nwr, rd0, wr0, n;
      dir_a = {base_g[31:12], va[31:22], 2'b00};
      tbl_a = {pde_in[31:12], va[21:12], 2'b00};
      mem[dir_a] = pde_in;
      mem[tbl_a] = pte_in;
      model(pde_in, pte_in, wr, usr, va, cause, pa, npde, npte, nrd, nwr);
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr; dir_base = base_g;
      @(negedge clk);
      chk(busy == 1'b1, {"R10 busy after accept ", tag}, 32'(busy), 32'h1);
      if (intr) begin
         req_vaddr = ~va; req_write = ~wr;
         @(negedge clk);
      end
      req_valid = 1'b0;
      n = 0;
      while (!done && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk(n < 400, {"R11 walk completes ", tag}, 32'(n), 32'd400);
      chk(done_fault == (cause != 2'd0), {"R11 fault flag ", tag}, 32'(done_fault), 32'(cause != 2'd0));
      chk(done_cause == cause, {"R3-R7 cause ", tag}, 32'(done_cause), 32'(cause));
      chk(done_paddr == pa, {"R1 paddr ", tag}, done_paddr, pa);
      chk(rd_cnt - rd0 == nrd, {"R3 R5 read count ", tag}, 32'(rd_cnt - rd0), 32'(nrd));
      chk(rd_log[rd0] == dir_a, {"R2 dir addr ", tag}, rd_log[rd0], dir_a);
      if (nrd == 2) chk(rd_log[rd0 + 1] == tbl_a, {"R2 tbl addr ", tag}, rd_log[rd0 + 1], tbl_a);
      chk(wr_cnt - wr0 == nwr, {"R8 write count ", tag}, 32'(wr_cnt - wr0), 32'(nwr));
      chk(peek(dir_a) == npde, {"R8 dir entry ", tag}, peek(dir_a), npde);
      chk(peek(tbl_a) == npte, {"R9 tbl entry ", tag}, peek(tbl_a), npte);
      @(negedge clk);
      chk(done == 1'b0, {"R11 done one cycle ", tag}, 32'(done), 32'h0);
      if (intr) begin
         repeat (4) @(negedge clk);
         chk(busy == 1'b0 && rd_cnt - rd0 == nrd, {"R10 request while busy ignored ", tag},
             32'(rd_cnt - rd0), 32'(nrd));
      end
   endtask

   function automatic logic [31:0] tbase(input logic [31:0] va);
      return 32'h2000_0000 | ({22'h0, va[31:22]} << 12);
   endfunction

   initial begin
      void'($urandom(32'd2024));
      fork
         mem_model();
         begin
            repeat (150000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      join_none

      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R11 reset state",
          {29'h0, busy, done, mem_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners; leaf base 0xABCDE
      do_walk(32'h0040_1234, 1'b0, 1'b0, tbase(32'h0040_1234) | 32'h006, 32'hABCDE_007, 1'b0, "R3 dir absent");
      do_walk(32'h0080_2345, 1'b0, 1'b0, tbase(32'h0080_2345) | 32'h087, 32'hABCDE_007, 1'b0, "R5 large page");
      do_walk(32'h00C0_3456, 1'b0, 1'b0, tbase(32'h00C0_3456) | 32'h007, 32'hABCDE_006, 1'b0, "R4 tbl absent");
      do_walk(32'h0100_4567, 1'b1, 1'b0, tbase(32'h0100_4567) | 32'h007, 32'hABCDE_005, 1'b0, "R6 write ro leaf");
      do_walk(32'h0140_5678, 1'b1, 1'b0, tbase(32'h0140_5678) | 32'h005, 32'hABCDE_007, 1'b0, "R6 write ro dir");
      do_walk(32'h0180_6789, 1'b0, 1'b1, tbase(32'h0180_6789) | 32'h007, 32'hABCDE_003, 1'b0, "R7 user on sup");
      do_walk(32'h01C0_789A, 1'b0, 1'b0, tbase(32'h01C0_789A) | 32'h003, 32'hABCDE_003, 1'b0, "R7 sup on sup ok");
      do_walk(32'h0200_89AB, 1'b0, 1'b1, tbase(32'h0200_89AB) | 32'h027, 32'hABCDE_027, 1'b0, "R8 no write");
      do_walk(32'h0240_9ABC, 1'b1, 1'b1, tbase(32'h0240_9ABC) | 32'h067, 32'hABCDE_067, 1'b0, "R9 A D set");
      do_walk(32'h0280_ABCD, 1'b1, 1'b0, tbase(32'h0280_ABCD) | 32'h023, 32'hABCDE_023, 1'b0, "R9 leaf only");
      do_walk(32'h02C0_BCDE, 1'b1, 1'b1, tbase(32'h02C0_BCDE) | 32'h007, 32'h12345_007, 1'b0, "R8 both writes");
      do_walk(32'h0300_CDEF, 1'b0, 1'b0, tbase(32'h0300_CDEF) | 32'h007, 32'h55555_007, 1'b1, "R10 intrude");
      do_walk(32'hFFFF_FFFF, 1'b1, 1'b1, tbase(32'hFFFF_FFFF) | 32'h007, 32'hFFFFF_007, 1'b0, "R1 top index");

      // constrained random walks
      for (int i = 0; i < 300; i++) begin
         logic [31:0] va, pde, pte;
         logic        wr, usr;
         va  = $urandom;
         wr  = 1'($urandom);
         usr = 1'($urandom);
         base_g = {16'h0001, 4'($urandom), 12'h000};
         pde = {tbase(va)[31:12], 12'($urandom)};
         pde[0] = ($urandom_range(0, 7) != 0);
         pde[7] = ($urandom_range(0, 7) == 0);
         pte = $urandom;
         pte[0] = ($urandom_range(0, 7) != 0);
         do_walk(va, wr, usr, pde, pte, 1'b0, "random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule